// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block performs the core-side part of taking an interrupt. It keeps a latched pending flag for each request source. At an instruction boundary, when the interrupt mask bit in the condition codes is clear, it picks the lowest-numbered pending source. It then writes a five-byte state frame to a stack that grows downward, one byte per cycle, through a byte-wide memory write port. When the frame is written, it hands the core a new stack pointer, new condition codes with the mask bit set, and a program counter equal to the vector base plus four times the source number.

The core holds off instruction fetch while `busy` is high. It copies `pc_out`, `sp_out` and `cc_out` into its own registers in the single cycle where `load` is high. The sequencer copies the PC, X, A, CC, SP and vector base inputs in the cycle it takes a request. Those inputs may change afterwards without affecting the entry in progress.

State machine: `ST_IDLE` waits. The take transition (`ST_IDLE` to `ST_PCL`) fires on `boundary` & pending & mask clear. The machine then steps unconditionally through the push states `ST_PCL`, `ST_PCH`, `ST_XR`, `ST_AR` and `ST_CCR`, one cycle each, and on to `ST_LOAD`. From `ST_LOAD` it returns to `ST_IDLE`. Reset forces `ST_IDLE` from any state.

Top module: `irq_entry_seq`

## Requirements
- R1: A synchronous active-high `rst` clears every pending flag and forces the idle state. While idle, `busy`, `mem_we`, `ack_valid` and `load` are 0. A request seen before reset is never taken after it.
- R2: A request is taken only on a clock edge where `boundary`=1, the machine is idle, at least one flag is pending, and `cc_in` bit 3 (the mask bit) is 0. Otherwise no entry starts.
- R3: When several flags are pending, the lowest index is taken. Exactly one source is taken per entry.
- R4: The taken source's flag is cleared. Every other pending flag stays set and is taken at a later qualifying boundary.
- R5: In the five cycles after the take edge, `mem_we`=1 with addresses SP, SP-1, SP-2, SP-3, SP-4. The data written are PC[7:0], PC[15:8], X, A and CC, in that order, where CC is the value sampled at the take edge.
- R6: In the cycle after the last write, `load`=1 for one cycle. In that cycle `sp_out` = SP-5, `cc_out` = the sampled CC with bit 3 set, and `pc_out` = vector base + 4 × index (16-bit wrap).
- R7: `ack_valid` is 1 for exactly one cycle, the cycle of the first write, with `ack_idx` giving the taken index.
- R8: `busy` is 1 from the first write cycle through the `load` cycle (6 cycles) and 0 otherwise. A `boundary` during `busy` starts nothing.
- R9: A one-cycle pulse on `req_in[i]` sets flag i, including while an entry is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_SRC | Request pulses, one bit per source |
| boundary | input | 1 | Instruction boundary strobe |
| pc_in | input | AW | Current program counter |
| x_in | input | DW | Current X register |
| a_in | input | DW | Current accumulator |
| cc_in | input | DW | Current condition codes (bit 3 = mask) |
| sp_in | input | AW | Current stack pointer |
| vec_base | input | AW | Vector base address |
| mem_we | output | 1 | Stack byte write enable |
| mem_addr | output | AW | Stack write address |
| mem_wdata | output | DW | Stack write data |
| pc_out | output | AW | New program counter, valid with load |
| sp_out | output | AW | New stack pointer, valid with load |
| cc_out | output | DW | New condition codes, valid with load |
| load | output | 1 | Core loads PC, SP, CC this cycle |
| ack_valid | output | 1 | One-cycle acknowledge |
| ack_idx | output | IDXW | Index of the taken source |
| busy | output | 1 | Sequence in progress, stall fetch |

## Verification
The bench drives inputs on the falling edge, and all outputs come from the state register. A result is therefore due one edge after its cause and is read at the next falling edge. The first write and the acknowledge appear one cycle after `boundary` is driven. Write k (k = 0 to 4) appears k+1 cycles after it, `load` appears 6 cycles after it, and idle returns 7 cycles after it. A request pulse is visible as pending one edge later, so the earliest take is on the following boundary edge. The checks that nothing starts sample `busy` and `mem_we` over several cycles after the masked or missing boundary. They then show that the flag survived by letting it be taken later.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PCL  = 3'd1,
        ST_PCH  = 3'd2,
        ST_XR   = 3'd3,
        ST_AR   = 3'd4,
        ST_CCR  = 3'd5,
        ST_LOAD = 3'd6
    } entry_state_t;
endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
    parameter int NUM_SRC = 4,
    parameter int IDXW    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_in,
    input  logic               clr_en,
    input  logic [IDXW-1:0]    clr_idx,
    output logic               pend_any,
    output logic [IDXW-1:0]    pend_idx
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_d;

    // a new pulse wins over the clear of the same source
    always_comb begin
        pend_d = pend_q;
        if (clr_en) pend_d[clr_idx] = 1'b0;
        pend_d = pend_d | req_in;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    // lowest index has priority: scan downward, last hit wins
    always_comb begin
        pend_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) pend_idx = IDXW'(i);
        end
    end

    assign pend_any = |pend_q;
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int IDXW = 2,
    parameter int IBIT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boundary,
    input  logic            pend_any,
    input  logic [IDXW-1:0] pend_idx,
    input  logic [AW-1:0]   pc_in,
    input  logic [DW-1:0]   x_in,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   cc_in,
    input  logic [AW-1:0]   sp_in,
    input  logic [AW-1:0]   vec_base,
    output logic            take,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [AW-1:0]   pc_out,
    output logic [AW-1:0]   sp_out,
    output logic [DW-1:0]   cc_out,
    output logic            load,
    output logic            ack_valid,
    output logic [IDXW-1:0] ack_idx,
    output logic            busy
);
    localparam logic [DW-1:0] MASK_SET = DW'(1) << IBIT;

    entry_state_t state_q, state_d;

    logic [AW-1:0]   pc_q, base_q, wptr_q;
    logic [DW-1:0]   x_q, a_q, cc_q;
    logic [IDXW-1:0] idx_q;

    assign take = (state_q == ST_IDLE) && boundary && pend_any && !cc_in[IBIT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_d = ST_PCL;
            ST_PCL:  state_d = ST_PCH;
            ST_PCH:  state_d = ST_XR;
            ST_XR:   state_d = ST_AR;
            ST_AR:   state_d = ST_CCR;
            ST_CCR:  state_d = ST_LOAD;
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // frame snapshot and write pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            base_q <= '0;
            wptr_q <= '0;
            x_q    <= '0;
            a_q    <= '0;
            cc_q   <= '0;
            idx_q  <= '0;
        end else if (take) begin
            pc_q   <= pc_in;
            base_q <= vec_base;
            wptr_q <= sp_in;
            x_q    <= x_in;
            a_q    <= a_in;
            cc_q   <= cc_in;
            idx_q  <= pend_idx;
        end else if (state_q != ST_IDLE && state_q != ST_LOAD) begin
            wptr_q <= wptr_q - AW'(1);
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = '0;
        load      = 1'b0;
        ack_valid = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_PCL: begin
                mem_we    = 1'b1;
                mem_wdata = pc_q[DW-1:0];
                ack_valid = 1'b1;
            end
            ST_PCH: begin
                mem_we    = 1'b1;
                mem_wdata = pc_q[AW-1:AW-DW];
            end
            ST_XR: begin
                mem_we    = 1'b1;
                mem_wdata = x_q;
            end
            ST_AR: begin
                mem_we    = 1'b1;
                mem_wdata = a_q;
            end
            ST_CCR: begin
                mem_we    = 1'b1;
                mem_wdata = cc_q;
            end
            ST_LOAD: load = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign mem_addr = wptr_q;
    assign sp_out   = wptr_q;
    assign cc_out   = cc_q | MASK_SET;
    assign pc_out   = base_q + AW'({idx_q, 2'b00});
    assign ack_idx  = idx_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int NUM_SRC = 4,
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int IBIT    = 3,
    parameter int IDXW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_in,
    input  logic               boundary,
    input  logic [AW-1:0]      pc_in,
    input  logic [DW-1:0]      x_in,
    input  logic [DW-1:0]      a_in,
    input  logic [DW-1:0]      cc_in,
    input  logic [AW-1:0]      sp_in,
    input  logic [AW-1:0]      vec_base,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    output logic [AW-1:0]      pc_out,
    output logic [AW-1:0]      sp_out,
    output logic [DW-1:0]      cc_out,
    output logic               load,
    output logic               ack_valid,
    output logic [IDXW-1:0]    ack_idx,
    output logic               busy
);
    logic            pend_any;
    logic [IDXW-1:0] pend_idx;
    logic            take;

    irq_pend_arb #(.NUM_SRC(NUM_SRC), .IDXW(IDXW)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req_in   (req_in),
        .clr_en   (take),
        .clr_idx  (pend_idx),
        .pend_any (pend_any),
        .pend_idx (pend_idx)
    );

    irq_entry_fsm #(.AW(AW), .DW(DW), .IDXW(IDXW), .IBIT(IBIT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .pend_any  (pend_any),
        .pend_idx  (pend_idx),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .a_in      (a_in),
        .cc_in     (cc_in),
        .sp_in     (sp_in),
        .vec_base  (vec_base),
        .take      (take),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc_out    (pc_out),
        .sp_out    (sp_out),
        .cc_out    (cc_out),
        .load      (load),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .busy      (busy)
    );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int IBIT = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          ack_valid,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          load,
    input logic [DW-1:0] cc_out
);
    // R8
    ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> busy);

    // R5
    we_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

    // R6
    load_mask_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> cc_out[IBIT]);

    // R6
    load_after_push_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> $past(mem_we));

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !ack_valid);

    // R8
    load_end_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !busy);
endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW), .DW(DW), .IBIT(IBIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .ack_valid (ack_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .load      (load),
    .cc_out    (cc_out)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  req_in;
    logic        boundary;
    logic [15:0] pc_in, sp_in, vec_base;
    logic [7:0]  x_in, a_in, cc_in;
    logic        mem_we, load, ack_valid, busy;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, cc_out;
    logic [1:0]  ack_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst(rst), .req_in(req_in), .boundary(boundary),
        .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
        .sp_in(sp_in), .vec_base(vec_base),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pc_out(pc_out), .sp_out(sp_out), .cc_out(cc_out), .load(load),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .busy(busy)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [3:0] r);
        @(negedge clk);
        req_in = r;
        @(negedge clk);
        req_in = '0;
    endtask

    task automatic idle_for(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(busy == 1'b0, tag, busy, 0);
            chk(mem_we == 1'b0, tag, mem_we, 0);
        end
    endtask

    // drives a qualifying boundary and checks the whole entry
    task automatic run_entry(input int idx, input logic [15:0] sp, input logic [15:0] pc,
                             input logic [7:0] x, input logic [7:0] a,
                             input logic [7:0] cc, input logic [15:0] base);
        logic [7:0] frame [5];
        frame[0] = pc[7:0];
        frame[1] = pc[15:8];
        frame[2] = x;
        frame[3] = a;
        frame[4] = cc;
        sp_in = sp; pc_in = pc; x_in = x; a_in = a; cc_in = cc; vec_base = base;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        pc_in = 16'hDEAD; x_in = 8'h55; a_in = 8'hAA; sp_in = 16'h1111; // snapshot must hold
        for (int k = 0; k < 5; k++) begin
            if (k == 0) begin
                chk(ack_valid == 1'b1, "R7 ack", ack_valid, 1);
                chk(ack_idx == 2'(idx), "R3 taken index", ack_idx, idx);
            end else begin
                chk(ack_valid == 1'b0, "R7 ack one cycle", ack_valid, 0);
            end
            chk(busy == 1'b1, "R8 busy in push", busy, 1);
            chk(mem_we == 1'b1, "R5 write enable", mem_we, 1);
            chk(mem_addr == sp - 16'(k), "R5 write address", mem_addr, sp - 16'(k));
            chk(mem_wdata == frame[k], "R5 write data", mem_wdata, frame[k]);
            @(negedge clk);
        end
        chk(load == 1'b1, "R6 load", load, 1);
        chk(mem_we == 1'b0, "R6 no write at load", mem_we, 0);
        chk(busy == 1'b1, "R8 busy at load", busy, 1);
        chk(sp_out == sp - 16'd5, "R6 new sp", sp_out, sp - 16'd5);
        chk(cc_out == (cc | 8'h08), "R6 new cc", cc_out, cc | 8'h08);
        chk(pc_out == base + 16'(4 * idx), "R6 vector", pc_out, base + 16'(4 * idx));
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy ends", busy, 0);
        chk(load == 1'b0, "R6 load one cycle", load, 0);
    endtask

    task automatic t_reset_state;
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
        chk(ack_valid == 1'b0, "R1 ack", ack_valid, 0);
        chk(load == 1'b0, "R1 load", load, 0);
    endtask

    task automatic t_single;
        pulse_req(4'b0100);
        run_entry(2, 16'h01FF, 16'h1234, 8'h9A, 8'h5C, 8'h01, 16'hFFE0);
        boundary = 1'b1;
        idle_for(3, "R4 flag cleared after take");
        boundary = 1'b0;
    endtask

    task automatic t_masked;
        pulse_req(4'b0010);
        cc_in = 8'h08;
        boundary = 1'b1;
        idle_for(3, "R2 masked");
        boundary = 1'b0;
        run_entry(1, 16'h0080, 16'h0400, 8'h11, 8'h22, 8'hF0, 16'h0100);
    endtask

    task automatic t_no_boundary;
        pulse_req(4'b1000);
        cc_in = 8'h00;
        boundary = 1'b0;
        idle_for(3, "R2 no boundary");
        run_entry(3, 16'h00C0, 16'hABCD, 8'h01, 8'h02, 8'h04, 16'hFFF4);
    endtask

    task automatic t_priority;
        pulse_req(4'b1011);
        run_entry(0, 16'h0100, 16'h2000, 8'h10, 8'h20, 8'h00, 16'h8000);
        run_entry(1, 16'h00FB, 16'h3000, 8'h30, 8'h40, 8'h02, 16'h8000);
        run_entry(3, 16'h00F6, 16'h4000, 8'h50, 8'h60, 8'h04, 16'h8000);
        boundary = 1'b1;
        cc_in = 8'h00;
        idle_for(2, "R4 all serviced");
        boundary = 1'b0;
    endtask

    task automatic t_req_while_busy;
        pulse_req(4'b1000);
        cc_in = 8'h00; sp_in = 16'h0200;
        boundary = 1'b1;
        @(negedge clk);
        chk(ack_idx == 2'd3, "R3 index 3", ack_idx, 3);
        req_in = 4'b0001;
        @(negedge clk);
        req_in = '0;
        repeat (4) @(negedge clk);
        chk(load == 1'b1, "R8 boundary ignored while busy", load, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8 idle one cycle", busy, 0);
        @(negedge clk);
        boundary = 1'b0;
        chk(ack_valid == 1'b1, "R9 latched while busy", ack_valid, 1);
        chk(ack_idx == 2'd0, "R9 index 0", ack_idx, 0);
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R8 finished", busy, 0);
    endtask

    task automatic t_reset_clears;
        pulse_req(4'b0010);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cc_in = 8'h00;
        boundary = 1'b1;
        idle_for(3, "R1 reset clears pending");
        boundary = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_in = '0; boundary = 1'b0;
        pc_in = '0; sp_in = '0; vec_base = '0; x_in = '0; a_in = '0; cc_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_single();
        t_masked();
        t_no_boundary();
        t_priority();
        t_req_while_busy();
        t_reset_clears();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule